// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block picks the slow timekeeping time base from one of two oscillator sources. Both sources reach it as single-cycle tick strobes in the system clock domain. The internal RC source runs fast and imprecise, so its ticks pass through two dividers in series: a fixed prescaler set at build time, then a programmable divider that divides by its register value plus one. The external crystal source is already at the target rate, so each of its ticks passes straight through.

The result is a one-cycle enable pulse, `slow_tick`, for downstream timekeeping logic. A gated copy, `pin_tick`, drives an output pin. Software programs the block through a small register interface with three registers. A write to the control register only counts if it carries a 16-bit key in its upper half. A change of source or divider waits for the end of the period in progress, so the output never produces a short period.

Top module: `lsc_clk_select`

## Requirements
- R1: After reset, every register reads zero, the internal source is active and the programmable divider is 0. The output period is then FIXED_DIV internal ticks and both pulse outputs are low.
- R2: The control register is at byte offset 0x00. A write to it changes the stored control bits only when write data bits [31:16] equal 0x16AA. Any other write there leaves the register and all outputs unchanged.
- R3: The control register has three fields. Bit 0 is the source select (0 = internal, 1 = external), bit 4 is the external oscillator enable, and bit 15 is the fallback bypass. Bit 4 drives `ext_osc_en` and bit 15 drives `fallback_bypass`. All other bits, including [31:16], read back as zero, so the key is never stored.
- R4: The prescaler register is at byte offset 0x08. It stores write data bits [4:0] and reads back those five bits with all other bits zero.
- R5: With the internal source active and prescaler value P, `slow_tick` pulses once every FIXED_DIV*(P+1) internal ticks, whatever the spacing between those ticks.
- R6: With the external source active, each `ext_osc_tick` produces a one-cycle `slow_tick` on the next clock cycle. There is no division, and the prescaler value has no effect.
- R7: Ticks from the source that is not active never produce a `slow_tick` and do not change the period of the active source.
- R8: A new source select or prescaler value takes effect at the next `slow_tick`. The period that is running when the register is written completes with the old settings.
- R9: The output gate register is at byte offset 0x60. Bit 0 set makes `pin_tick` equal `slow_tick`; bit 0 clear holds `pin_tick` low. The register reads back bit 0 only.
- R10: A write to any other offset changes no register, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| int_osc_tick | input | 1 | One-cycle strobe per internal oscillator edge |
| ext_osc_tick | input | 1 | One-cycle strobe per external oscillator edge |
| slow_tick | output | 1 | Divided timekeeping enable pulse |
| pin_tick | output | 1 | Gated copy of `slow_tick` for the output pin |
| ext_osc_en | output | 1 | External oscillator enable control bit |
| fallback_bypass | output | 1 | Fallback-bypass control bit |

## Verification
The internal path is tested with every prescaler value from 0 to 31. The fixed prescaler is set to 4 so the test runs quickly. Internal ticks arrive on every cycle in one pass and on every third cycle in another. These two patterns separate a divider that counts ticks from one that counts clock cycles, and the full sweep catches off-by-one errors in either divider stage.

Some writes land in the middle of a period, to check that the output only changes at a period boundary. Others omit the key or are aimed at unmapped offsets, to check that they change nothing. Both sources run together in both directions, to show that the source not selected has no influence on the output.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int LSC_DW = 32;

    // Register byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_PRESC = 8'h08;
    localparam logic [7:0] OFS_GATE  = 8'h60;

    // Write key carried in the upper halfword of a control write
    localparam logic [15:0] CTRL_KEY = 16'h16AA;

    // Control field positions
    localparam int BIT_SRC    = 0;
    localparam int BIT_EXTEN  = 4;
    localparam int BIT_BYPASS = 15;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } lsc_src_e;

    typedef struct packed {
        logic     bypass;
        logic     ext_en;
        lsc_src_e src;
    } lsc_ctrl_t;

    function automatic logic key_ok(input logic [LSC_DW-1:0] w);
        return w[LSC_DW-1:16] == CTRL_KEY;
    endfunction

    function automatic lsc_ctrl_t ctrl_unpack(input logic [LSC_DW-1:0] w);
        lsc_ctrl_t c;
        c.bypass = w[BIT_BYPASS];
        c.ext_en = w[BIT_EXTEN];
        c.src    = lsc_src_e'(w[BIT_SRC]);
        return c;
    endfunction

    function automatic logic [LSC_DW-1:0] ctrl_pack(input lsc_ctrl_t c);
        logic [LSC_DW-1:0] w;
        w             = '0;
        w[BIT_BYPASS] = c.bypass;
        w[BIT_EXTEN]  = c.ext_en;
        w[BIT_SRC]    = c.src;
        return w;
    endfunction

endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
    import lsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PDIV_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LSC_DW-1:0]   wdata,
    output logic [LSC_DW-1:0]   rdata,
    output lsc_ctrl_t           ctrl,
    output logic [PDIV_W-1:0]   pdiv,
    output logic                gate_en
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFS_PRESC);
    localparam logic [ADDR_W-1:0] A_GATE  = ADDR_W'(OFS_GATE);

    logic hit_ctrl, hit_presc, hit_gate;

    assign hit_ctrl  = (addr == A_CTRL);
    assign hit_presc = (addr == A_PRESC);
    assign hit_gate  = (addr == A_GATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '{bypass: 1'b0, ext_en: 1'b0, src: SRC_INT};
            pdiv    <= '0;
            gate_en <= 1'b0;
        end else if (we) begin
            if (hit_ctrl && key_ok(wdata)) ctrl <= ctrl_unpack(wdata);
            if (hit_presc)                 pdiv <= wdata[PDIV_W-1:0];
            if (hit_gate)                  gate_en <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl)       rdata = ctrl_pack(ctrl);
        else if (hit_presc) rdata = LSC_DW'(pdiv);
        else if (hit_gate)  rdata = LSC_DW'(gate_en);
    end

    p_key_guard_r2: assert property (@(posedge clk) disable iff (rst)
        (we && hit_ctrl && !key_ok(wdata)) |=> $stable(ctrl));

    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (we && !hit_ctrl && !hit_presc && !hit_gate)
            |=> ($stable(ctrl) && $stable(pdiv) && $stable(gate_en)));

    p_key_high_zero_r3: assert property (@(posedge clk) disable iff (rst)
        hit_ctrl |-> (rdata[LSC_DW-1:16] == 16'h0));

endmodule

// File: rtl/lsc_divider.sv
module lsc_divider
    import lsc_pkg::*;
#(
    parameter int FIXED_DIV = 32,
    parameter int PDIV_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_tick,
    input  logic              ext_tick,
    input  lsc_src_e          req_src,
    input  logic [PDIV_W-1:0] req_pdiv,
    output logic              tick_o,
    output lsc_src_e          act_src_o
);

    lsc_src_e          act_src;
    logic [PDIV_W-1:0] act_pdiv;
    logic [PDIV_W-1:0] div_cnt;
    logic              pre_pulse;
    logic              int_fire;
    logic              fire;

    // Stage 1: fixed prescaler, held at zero while the external source runs
    generate
        if (FIXED_DIV > 1) begin : g_pre
            localparam int PRE_W = $clog2(FIXED_DIV);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(FIXED_DIV - 1);

            logic [PRE_W-1:0] pre_cnt;
            logic             pre_wrap;

            assign pre_wrap  = (pre_cnt == PRE_LAST);
            assign pre_pulse = int_tick && pre_wrap && (act_src == SRC_INT);

            always_ff @(posedge clk) begin
                if (rst || act_src == SRC_EXT)
                    pre_cnt <= '0;
                else if (int_tick)
                    pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
            end

            p_pre_bound_r5: assert property (@(posedge clk) disable iff (rst)
                pre_cnt <= PRE_LAST);
        end else begin : g_nopre
            assign pre_pulse = int_tick && (act_src == SRC_INT);
        end
    endgenerate

    // Stage 2: programmable divide by (value + 1)
    assign int_fire = pre_pulse && (div_cnt == act_pdiv);
    assign fire     = (act_src == SRC_EXT) ? ext_tick : int_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_src  <= SRC_INT;
            act_pdiv <= '0;
            div_cnt  <= '0;
            tick_o   <= 1'b0;
        end else begin
            tick_o <= fire;
            if (fire) begin
                act_src  <= req_src;
                act_pdiv <= req_pdiv;
                div_cnt  <= '0;
            end else if (pre_pulse) begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign act_src_o = act_src;

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= act_pdiv);

    p_ext_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (act_src == SRC_EXT && ext_tick) |=> tick_o);

    p_ext_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (act_src == SRC_EXT && !ext_tick) |=> !tick_o);

    p_int_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (act_src == SRC_INT && !int_tick) |=> !tick_o);

    p_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(act_src) && $stable(act_pdiv)));

endmodule

// File: rtl/lsc_clk_select.sv
module lsc_clk_select
    import lsc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PDIV_W    = 5,
    parameter int FIXED_DIV = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              int_osc_tick,
    input  logic              ext_osc_tick,
    output logic              slow_tick,
    output logic              pin_tick,
    output logic              ext_osc_en,
    output logic              fallback_bypass
);

    lsc_ctrl_t         ctrl;
    logic [PDIV_W-1:0] pdiv;
    logic              gate_en;
    lsc_src_e          act_src;

    lsc_regs #(
        .ADDR_W (ADDR_W),
        .PDIV_W (PDIV_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .ctrl    (ctrl),
        .pdiv    (pdiv),
        .gate_en (gate_en)
    );

    lsc_divider #(
        .FIXED_DIV (FIXED_DIV),
        .PDIV_W    (PDIV_W)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .int_tick  (int_osc_tick),
        .ext_tick  (ext_osc_tick),
        .req_src   (ctrl.src),
        .req_pdiv  (pdiv),
        .tick_o    (slow_tick),
        .act_src_o (act_src)
    );

    assign pin_tick        = slow_tick & gate_en;
    assign ext_osc_en      = ctrl.ext_en;
    assign fallback_bypass = ctrl.bypass;

    p_pin_subset_r9: assert property (@(posedge clk) disable iff (rst)
        pin_tick |-> slow_tick);

    p_src_from_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (act_src != $past(act_src)) |-> ($past(slow_tick) == 1'b0 && slow_tick));

endmodule

// File: tb/tb_lsc_clk_select.sv
module tb_lsc_clk_select;

    localparam int FD    = 4;
    localparam int AW    = 8;
    localparam int PW    = 5;
    localparam int LIMIT = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        int_osc_tick = 1'b0;
    logic        ext_osc_tick = 1'b0;
    logic        slow_tick, pin_tick, ext_osc_en, fallback_bypass;

    int compared = 0;
    int mismatched = 0;
    int int_gap = 0;
    int ext_gap = 0;
    int cyc = 0;
    bit done = 0;

    lsc_clk_select #(.ADDR_W(AW), .PDIV_W(PW), .FIXED_DIV(FD)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_osc_tick(int_osc_tick), .ext_osc_tick(ext_osc_tick),
        .slow_tick(slow_tick), .pin_tick(pin_tick),
        .ext_osc_en(ext_osc_en), .fallback_bypass(fallback_bypass)
    );

    always #2.5 clk = ~clk;

    // Tick generator and cycle counter, updated away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            int_osc_tick = (int_gap != 0) && (cyc % int_gap == 0);
            ext_osc_tick = (ext_gap != 0) && (cyc % ext_gap == 0);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Returns the cycle stamp of the next slow_tick, or -1 on timeout
    task automatic next_pulse(output int stamp);
        stamp = -1;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            #0.5;
            if (slow_tick) begin stamp = cyc; return; end
        end
    endtask

    task automatic period(output int p);
        int a, b;
        next_pulse(a);
        next_pulse(b);
        p = (a < 0 || b < 0) ? -1 : b - a;
    endtask

    initial begin
        logic [31:0] d;
        int p, a, b, cnt, mis;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(8'h00, d); check("R1 ctrl", d, 0);
        rd(8'h08, d); check("R1 presc", d, 0);
        rd(8'h60, d); check("R1 gate", d, 0);
        check("R1 slow_tick", slow_tick, 0);
        check("R1 pin_tick", pin_tick, 0);
        int_gap = 1;
        period(p); check("R1 default period", p, FD);

        // R4: prescaler keeps five bits only
        wr(8'h08, 32'hFFFF_FFE5);
        rd(8'h08, d); check("R4 presc readback", d, 5);

        // R5: full sweep, ticks every cycle
        mis = 0;
        for (int v = 0; v < 32; v++) begin
            wr(8'h08, v);
            next_pulse(a);
            period(p);
            compared++;
            if (p != FD * (v + 1)) begin
                mismatched++; mis++;
                $display("FAIL R5 sweep P=%0d: actual %0d expected %0d", v, p, FD * (v + 1));
            end
        end
        // R5: ticks every third cycle
        int_gap = 3;
        for (int v = 0; v < 8; v++) begin
            wr(8'h08, v);
            next_pulse(a);
            period(p);
            check("R5 gap3", p, 3 * FD * (v + 1));
        end
        int_gap = 1;

        // R8: divider change mid-period completes old period
        wr(8'h08, 7);
        next_pulse(a);
        next_pulse(a);
        repeat (10) @(negedge clk);
        wr(8'h08, 0);
        next_pulse(b); check("R8 old period kept", b - a, FD * 8);
        next_pulse(a); check("R8 new period", a - b, FD);

        // R2: control write without key is ignored
        wr(8'h00, 32'h0000_8011);
        rd(8'h00, d); check("R2 no key ctrl", d, 0);
        check("R2 no key ext_en", ext_osc_en, 0);
        period(p); check("R2 source kept", p, FD);

        // R9: gate off keeps pin quiet
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #0.5; if (pin_tick) cnt++;
        end
        check("R9 pin gated off", cnt, 0);
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, d); check("R9 gate readback", d, 1);
        mis = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #0.5; if (pin_tick != slow_tick) mis++;
        end
        check("R9 pin follows", mis, 0);

        // R7: external ticks do not disturb the internal period
        wr(8'h08, 1);
        ext_gap = 3;
        next_pulse(a);
        period(p); check("R7 int period with ext ticks", p, FD * 2);
        ext_gap = 0;

        // R3/R8: keyed switch to external, mid-period
        next_pulse(a);
        repeat (2) @(negedge clk);
        wr(8'h00, 32'h16AA_FFFF);
        rd(8'h00, d); check("R3 ctrl readback", d, 32'h0000_8011);
        check("R3 ext_en pin", ext_osc_en, 1);
        check("R3 bypass pin", fallback_bypass, 1);
        next_pulse(b); check("R8 switch waits boundary", b - a, FD * 2);

        // R7: internal ticks ignored while external is active
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #0.5; if (slow_tick) cnt++;
        end
        check("R7 int ignored in ext mode", cnt, 0);

        // R6: external passes undivided, prescaler ignored
        ext_gap = 5;
        period(p); check("R6 ext period", p, 5);
        wr(8'h08, 31);
        next_pulse(a);
        period(p); check("R6 presc no effect", p, 5);
        ext_gap = 2;
        next_pulse(a);
        period(p); check("R6 ext gap2", p, 2);

        // R8: switch back to internal at an external boundary
        ext_gap = 7;
        wr(8'h08, 2);
        wr(8'h00, 32'h16AA_0000);
        next_pulse(a);
        ext_gap = 0;
        period(p); check("R8 back to int", p, FD * 3);
        check("R3 ext_en cleared", ext_osc_en, 0);

        // R10: unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h20, 32'h16AA_FFFF);
        rd(8'h04, d); check("R10 unmapped read", d, 0);
        rd(8'h00, d); check("R10 ctrl untouched", d, 0);
        rd(8'h08, d); check("R10 presc untouched", d, 2);
        rd(8'h60, d); check("R10 gate untouched", d, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule